// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable total ratio P·N + A, the way a synthesizer loop divides its oscillator before phase comparison. A base counter stands in for the dual-modulus prescaler: it counts input clocks in periods of P or P+1. A swallow count A sets how many of those periods use P+1. A main count N sets how many periods make up one output cycle. The base modulus P is 64 or 128, picked by a select input. At the end of each output cycle the block emits a single-clock pulse toward the phase detector.

The configuration inputs are held by the surrounding logic. The block samples them only at an output-cycle boundary, so a new channel never breaks a cycle that is already running. An optional reference counter divides a separate oscillator clock by R and emits its own one-cycle pulse. Together the two pulses satisfy f_in/(P·N + A) = f_osc/R when the loop is locked. The generate parameter `HAS_REF` decides whether the reference counter is built.

Top module: `swallow_synth_div`

## Requirements
- R1: While `rst` is high, `fp_pulse` and `fr_pulse` are 0 from the first clock edge of their own domain onward.
- R2: With `cfg_narrow` = 1 (P = 64), successive `fp_pulse` highs are exactly 64·N + A `clk` cycles apart.
- R3: With `cfg_narrow` = 0 (P = 128), successive `fp_pulse` highs are exactly 128·N + A `clk` cycles apart.
- R4: Each `fp_pulse` is high for exactly one `clk` cycle.
- R5: After `rst` falls, the first `fp_pulse` follows the (P·N + A)-th rising `clk` edge with `rst` low, counted from the first such edge.
- R6: Within each output cycle, `dual_hi` is high for exactly (P+1)·A `clk` cycles, and only at the start of the cycle. The high stretch begins in the cycle in which `fp_pulse` is high.
- R7: With A = 0, `dual_hi` stays low for the whole cycle and the spacing is P·N.
- R8: A change of A, N or the modulus select in the middle of a cycle leaves that cycle's length unchanged. The new values set the length of the next cycle. They are captured at the edge that raises `fp_pulse`.
- R9: `fr_pulse` is high for one `osc_clk` cycle every R `osc_clk` cycles, for R from 8 up to 16383. A new R takes effect from the next pulse.
- R10: The ratio holds at the edges of the legal range: A = N − 1 with N = 16, and A = 127 with N = 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rst | input | 1 | Synchronous active-high reset for both domains |
| cfg_narrow | input | 1 | Modulus select: 1 gives P = 64, 0 gives P = 128 |
| cfg_swallow | input | A_W | Swallow count A (0..127, below N) |
| cfg_main | input | N_W | Main count N (16..2047) |
| osc_clk | input | 1 | Reference oscillator clock |
| cfg_ref | input | R_W | Reference divide ratio R (8..16383) |
| fp_pulse | output | 1 | One-clock pulse at the end of each divided cycle |
| dual_hi | output | 1 | High while the prescaler is in its P+1 mode |
| fr_pulse | output | 1 | One-osc-clock pulse every R oscillator cycles |

## Verification
The assertions assume legal configuration: N at least 16, A below N, and R at least 8. Under those limits a cycle is always far longer than two clocks, so the pulses can never merge. They also assume that `rst` is held for several cycles of both clocks, so each domain sees it. The bench writes configuration only in those ranges and holds reset for five fast clocks, which spans more than three oscillator edges. It changes configuration mid-cycle only to show that the running cycle ignores the change.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned DEF_P_LO = 64;
  localparam int unsigned DEF_A_W  = 7;
  localparam int unsigned DEF_N_W  = 11;
  localparam int unsigned DEF_R_W  = 14;

  typedef enum logic {
    PM_BASE = 1'b0,
    PM_PLUS = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler
  import swd_pkg::*;
#(
  parameter int unsigned P_LO = DEF_P_LO
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      narrow,
  input  pre_mode_e mode,
  output logic      period_end
);
  localparam int unsigned P_HI = 2 * P_LO;
  localparam int unsigned CW   = $clog2(P_HI + 1);

  logic [CW-1:0] pc_q;
  logic [CW-1:0] last;

  // last count of the current period: P-1 in base mode, P in plus mode
  always_comb begin
    last = narrow ? CW'(P_LO - 1) : CW'(P_HI - 1);
    if (mode == PM_PLUS) last = last + CW'(1);
  end

  assign period_end = (pc_q == last);

  always_ff @(posedge clk) begin
    if (rst)             pc_q <= '0;
    else if (period_end) pc_q <= '0;
    else                 pc_q <= pc_q + CW'(1);
  end
endmodule

// File: rtl/swd_cycle_ctl.sv
module swd_cycle_ctl
  import swd_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W,
  parameter int unsigned N_W = DEF_N_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           period_end,
  input  logic           cfg_narrow,
  input  logic [A_W-1:0] cfg_a,
  input  logic [N_W-1:0] cfg_n,
  output logic           narrow_q,
  output pre_mode_e      mode,
  output logic           cycle_end
);
  logic [A_W-1:0] a_q;
  logic [N_W-1:0] n_q;

  assign mode      = (a_q != '0) ? PM_PLUS : PM_BASE;
  assign cycle_end = period_end && (n_q == N_W'(1));

  // counters double as the shadow copy: inputs are only sampled on reload
  always_ff @(posedge clk) begin
    if (rst || cycle_end) begin
      a_q      <= cfg_a;
      n_q      <= cfg_n;
      narrow_q <= cfg_narrow;
    end else if (period_end) begin
      n_q <= n_q - N_W'(1);
      if (a_q != '0) a_q <= a_q - A_W'(1);
    end
  end
endmodule

// File: rtl/swd_ref_div.sv
module swd_ref_div
  import swd_pkg::*;
#(
  parameter int unsigned R_W = DEF_R_W
) (
  input  logic           osc_clk,
  input  logic           rst,
  input  logic [R_W-1:0] cfg_r,
  output logic           fr_pulse
);
  logic [R_W-1:0] r_q;

  always_ff @(posedge osc_clk) begin
    if (rst) begin
      r_q      <= cfg_r;
      fr_pulse <= 1'b0;
    end else if (r_q == R_W'(1)) begin
      r_q      <= cfg_r;
      fr_pulse <= 1'b1;
    end else begin
      r_q      <= r_q - R_W'(1);
      fr_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/swallow_synth_div.sv
module swallow_synth_div
  import swd_pkg::*;
#(
  parameter int unsigned P_LO    = DEF_P_LO,
  parameter int unsigned A_W     = DEF_A_W,
  parameter int unsigned N_W     = DEF_N_W,
  parameter int unsigned R_W     = DEF_R_W,
  parameter bit          HAS_REF = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_narrow,
  input  logic [A_W-1:0] cfg_swallow,
  input  logic [N_W-1:0] cfg_main,
  input  logic           osc_clk,
  input  logic [R_W-1:0] cfg_ref,
  output logic           fp_pulse,
  output logic           dual_hi,
  output logic           fr_pulse
);
  logic      period_end;
  logic      cycle_end;
  logic      narrow_q;
  pre_mode_e mode;

  swd_prescaler #(.P_LO(P_LO)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .narrow     (narrow_q),
    .mode       (mode),
    .period_end (period_end)
  );

  swd_cycle_ctl #(.A_W(A_W), .N_W(N_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end),
    .cfg_narrow (cfg_narrow),
    .cfg_a      (cfg_swallow),
    .cfg_n      (cfg_main),
    .narrow_q   (narrow_q),
    .mode       (mode),
    .cycle_end  (cycle_end)
  );

  assign dual_hi = (mode == PM_PLUS);

  always_ff @(posedge clk) begin
    if (rst) fp_pulse <= 1'b0;
    else     fp_pulse <= cycle_end;
  end

  generate
    if (HAS_REF) begin : g_ref
      swd_ref_div #(.R_W(R_W)) u_ref (
        .osc_clk  (osc_clk),
        .rst      (rst),
        .cfg_r    (cfg_ref),
        .fr_pulse (fr_pulse)
      );
    end else begin : g_noref
      assign fr_pulse = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/swallow_synth_div_chk.sv
module swallow_synth_div_chk #(
  parameter int unsigned P_LO = 64,
  parameter int unsigned CW   = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          osc_clk,
  input logic          fp_pulse,
  input logic          fr_pulse,
  input logic          dual_hi,
  input logic          narrow_q,
  input logic [CW-1:0] pc
);
  // R1: reset silences the divided output
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !fp_pulse);

  // R2/R3: base counter never runs past the longest period (2P+1 states)
  p_pc_range_r2: assert property (@(posedge clk) disable iff (rst)
    pc <= CW'(2 * P_LO));

  // R4: divided pulse lasts one clock
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    fp_pulse |=> !fp_pulse);

  // R6: the P+1 stretch can only start on a cycle boundary
  p_plus_starts_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dual_hi) |-> fp_pulse);

  // R8: the modulus select only moves at a cycle boundary
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(narrow_q) |-> fp_pulse);

  // R9: reference pulse lasts one oscillator clock
  p_ref_single_r9: assert property (@(posedge osc_clk) disable iff (rst)
    fr_pulse |=> !fr_pulse);
endmodule

bind swallow_synth_div swallow_synth_div_chk #(
  .P_LO (P_LO),
  .CW   ($clog2(2 * P_LO + 1))
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .osc_clk  (osc_clk),
  .fp_pulse (fp_pulse),
  .fr_pulse (fr_pulse),
  .dual_hi  (dual_hi),
  .narrow_q (narrow_q),
  .pc       (u_pre.pc_q)
);

// File: tb/swallow_synth_div_bench.sv
module swallow_synth_div_bench;
  logic        clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_narrow = 1'b1;
  logic [6:0]  cfg_swallow = 7'd3;
  logic [10:0] cfg_main = 11'd16;
  logic [13:0] cfg_ref = 14'd8;
  logic        fp_pulse, dual_hi, fr_pulse;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;
  always #3.5 osc_clk = ~osc_clk;

  swallow_synth_div u_swallow_synth_div (
    .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow), .cfg_swallow(cfg_swallow),
    .cfg_main(cfg_main), .osc_clk(osc_clk), .cfg_ref(cfg_ref),
    .fp_pulse(fp_pulse), .dual_hi(dual_hi), .fr_pulse(fr_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit nar, input int a, input int n);
    cfg_narrow  = nar;
    cfg_swallow = 7'(a);
    cfg_main    = 11'(n);
  endtask

  // counts clk cycles up to and including the next fp_pulse state
  task automatic wait_fp(output int gap, output int hi);
    gap = 0; hi = 0;
    do begin
      @(negedge clk);
      gap++;
      if (dual_hi) hi++;
    end while (!fp_pulse);
  endtask

  task automatic wait_fr(output int gap);
    gap = 0;
    do begin
      @(negedge osc_clk);
      gap++;
    end while (!fr_pulse);
  endtask

  // apply config, then land on the start of a cycle that uses it
  task automatic apply(input bit nar, input int a, input int n);
    int g, h;
    set_cfg(nar, a, n);
    wait_fp(g, h);
  endtask

  task automatic t_reset;
    int g, h;
    rst = 1'b1;
    set_cfg(1'b1, 3, 16);
    repeat (5) @(negedge clk);
    chk(fp_pulse == 1'b0, "R1 fp_pulse in reset", int'(fp_pulse), 0);
    chk(fr_pulse == 1'b0, "R1 fr_pulse in reset", int'(fr_pulse), 0);
    rst = 1'b0;
    wait_fp(g, h);
    chk(g == 1027, "R5 first pulse after reset", g, 1027);
  endtask

  task automatic t_narrow;
    int g, h;
    wait_fp(g, h);
    chk(g == 1027, "R2 spacing P=64 A=3 N=16", g, 1027);
    chk(h == 195, "R6 plus cycles A=3", h, 195);
    chk(dual_hi == 1'b1, "R6 plus mode starts with pulse", int'(dual_hi), 1);
    @(negedge clk);
    chk(fp_pulse == 1'b0, "R4 pulse width", int'(fp_pulse), 0);
  endtask

  task automatic t_wide;
    int g, h;
    apply(1'b0, 5, 16);
    wait_fp(g, h);
    chk(g == 2053, "R3 spacing P=128 A=5 N=16", g, 2053);
    chk(h == 645, "R6 plus cycles P=128 A=5", h, 645);
  endtask

  task automatic t_zero;
    int g, h;
    apply(1'b1, 0, 20);
    wait_fp(g, h);
    chk(g == 1280, "R7 spacing A=0", g, 1280);
    chk(h == 0, "R7 no plus mode A=0", h, 0);
  endtask

  task automatic t_midchange;
    int g, h;
    apply(1'b1, 2, 16);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (g == 200) set_cfg(1'b0, 9, 17);
    end while (!fp_pulse);
    chk(g == 1026, "R8 running cycle keeps old ratio", g, 1026);
    wait_fp(g, h);
    chk(g == 2185, "R8 next cycle takes new ratio", g, 2185);
    chk(h == 1161, "R8 next cycle new swallow", h, 1161);
  endtask

  task automatic t_bounds;
    int g, h;
    apply(1'b1, 15, 16);
    wait_fp(g, h);
    chk(g == 1039, "R10 spacing A=15 N=16", g, 1039);
    chk(h == 975, "R10 plus cycles A=15", h, 975);
    apply(1'b1, 127, 128);
    wait_fp(g, h);
    chk(g == 8319, "R10 spacing A=127 N=128", g, 8319);
    chk(h == 8255, "R10 plus cycles A=127", h, 8255);
  endtask

  task automatic t_ref;
    int g;
    wait_fr(g);
    wait_fr(g);
    chk(g == 8, "R9 reference R=8", g, 8);
    @(negedge osc_clk);
    chk(fr_pulse == 1'b0, "R9 reference pulse width", int'(fr_pulse), 0);
    cfg_ref = 14'd100;
    wait_fr(g);
    wait_fr(g);
    chk(g == 100, "R9 reference R=100", g, 100);
    cfg_ref = 14'd16383;
    wait_fr(g);
    wait_fr(g);
    chk(g == 16383, "R9 reference R=16383", g, 16383);
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_zero();
    t_midchange();
    t_bounds();
    t_ref();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule